// File: doc/BRIEF.md
# Masked Vector Register Move Unit

This block is one registered pipeline stage that moves a packed vector of 32-bit lanes into a destination of up to 512 bits. Each lane is either taken from the source or filled from a fallback. The fallback keeps the old destination lane (merge) or writes zero (zeroing). Which one applies depends on a per-lane mask, a mask-enable flag, a merge/zero select, the operation form (register copy, load or store) and the encoding class (legacy, plain extended or masked extended).

Bits above the selected vector length follow the encoding class and the form. Extended register-copy and load operations clear them. Legacy operations keep them. Stores never write them.

A 4-bit reserved operand field must read all ones. Any other value, and any combination that is not allowed, raises an undefined-opcode fault and leaves the destination exactly as it was. The data is treated as raw bits: no floating-point handling, and no alignment or memory checks.

Top module: `vmove_mask_unit`

## Requirements
- R1: Lane j occupies bits 32j+31..32j. A lane inside the vector length (4 lanes for vl_sel=0 / 128 bits, 8 for vl_sel=1 / 256 bits, 16 for vl_sel=2 / 512 bits) is copied bit-exact from src_vec when masking is in force and its lane_mask bit is 1, or when masking is not in force.
- R2: For form_sel 0 (register copy) or 1 (load), with masking in force and zero_sel=0, a lane inside the vector length whose mask bit is 0 keeps its dst_vec value.
- R3: For form_sel 0 or 1, with masking in force and zero_sel=1, a lane inside the vector length whose mask bit is 0 becomes zero.
- R4: For form_sel 2 (store), with masking in force, a lane whose mask bit is 0 keeps its dst_vec value whatever zero_sel is.
- R5: For enc_sel 1 (plain extended) or 2 (masked extended) in form 0 or 1, every lane above the vector length is zero.
- R6: For form 2 (store), every lane above the vector length keeps its dst_vec value.
- R7: For enc_sel 0 (legacy) in form 0 or 1, bits 511..128 keep their dst_vec value.
- R8: When rsvd_field is not 4'b1111, out_fault is 1 and out_data equals dst_vec.
- R9: out_fault is also 1, with out_data equal to dst_vec, when any of these holds: vl_sel=3; form_sel=3; enc_sel=3; enc_sel 0 with vl_sel other than 0; enc_sel 1 with vl_sel 2. Otherwise out_fault is 0.
- R10: Masking is in force only when enc_sel=2 and mask_en=1. In every other case lane_mask has no effect on out_data.
- R11: out_valid goes high one clock after in_valid and is low otherwise. out_data and out_fault are updated only on an accepted in_valid and hold between operations. A synchronous active-high rst clears out_valid, out_data and out_fault.
- R12: Lane contents that look like NaN or denormal patterns are passed through unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_vec | input | 512 | Source vector |
| dst_vec | input | 512 | Current destination contents |
| lane_mask | input | 16 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | Use the mask (masked extended class only) |
| zero_sel | input | 1 | 1 = zeroing, 0 = merging for unselected lanes |
| vl_sel | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits, 3 = illegal |
| form_sel | input | 2 | 0 = register copy, 1 = load, 2 = store, 3 = illegal |
| enc_sel | input | 2 | 0 = legacy, 1 = plain extended, 2 = masked extended, 3 = illegal |
| rsvd_field | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| out_data | output | 512 | New destination vector |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
The fault decision and the per-lane masking both fall into the same cycle. A bad reserved field or an illegal combination must override a masked merge or zeroing that would otherwise rewrite lanes. The sweep provokes this by pairing every mask, zero-select, form, class and length with both a legal and an illegal reserved value. Each case is judged lane by lane against a destination that must come back untouched whenever a fault is expected. Upper-bit clearing and lane zeroing also coincide in short-vector extended loads, and those are judged lane by lane in the same way.

// File: rtl/vmov_pkg.sv
package vmov_pkg;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_BAD = 2'd3
    } vlen_e;

    typedef enum logic [1:0] {
        FORM_COPY  = 2'd0,
        FORM_LOAD  = 2'd1,
        FORM_STORE = 2'd2,
        FORM_BAD   = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_PLAIN  = 2'd1,
        ENC_MASKED = 2'd2,
        ENC_BAD    = 2'd3
    } enc_e;

endpackage

// File: rtl/vmov_decode.sv
module vmov_decode
    import vmov_pkg::*;
#(
    parameter int MAX_LANES = 16
) (
    input  logic [1:0]           vl_sel,
    input  logic [1:0]           form_sel,
    input  logic [1:0]           enc_sel,
    input  logic [3:0]           rsvd_field,
    input  logic                 mask_en,
    output logic                 fault,
    output logic [MAX_LANES-1:0] lane_active,
    output logic                 mask_on,
    output logic                 is_store,
    output logic                 clr_upper
);
    localparam int SPAN_W     = $clog2(MAX_LANES) + 1;
    localparam int BASE_LANES = MAX_LANES / 4;

    logic [SPAN_W-1:0] span;
    logic              combo_bad;

    always_comb begin
        unique case (vl_sel)
            VL_128:  span = SPAN_W'(BASE_LANES);
            VL_256:  span = SPAN_W'(2 * BASE_LANES);
            default: span = SPAN_W'(MAX_LANES);
        endcase
    end

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_span
        assign lane_active[j] = (SPAN_W'(j) < span);
    end

    always_comb begin
        combo_bad = 1'b0;
        if (vl_sel == VL_BAD || form_sel == FORM_BAD || enc_sel == ENC_BAD)
            combo_bad = 1'b1;
        if (enc_sel == ENC_LEGACY && vl_sel != VL_128)
            combo_bad = 1'b1;
        if (enc_sel == ENC_PLAIN && vl_sel == VL_512)
            combo_bad = 1'b1;
    end

    assign fault     = combo_bad || (rsvd_field != 4'b1111);
    assign mask_on   = (enc_sel == ENC_MASKED) && mask_en;
    assign is_store  = (form_sel == FORM_STORE);
    assign clr_upper = (enc_sel != ENC_LEGACY) && !is_store;

endmodule

// File: rtl/vmov_lane.sv
module vmov_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] src,
    input  logic [LANE_W-1:0] dst,
    input  logic              active,
    input  logic              pick,
    input  logic              is_store,
    input  logic              clr_upper,
    input  logic              zero_mode,
    output logic [LANE_W-1:0] res
);
    always_comb begin
        if (active) begin
            if (pick)
                res = src;
            else if (!is_store && zero_mode)
                res = '0;
            else
                res = dst;
        end else begin
            res = clr_upper ? '0 : dst;
        end
    end
endmodule

// File: rtl/vmove_mask_unit.sv
module vmove_mask_unit
    import vmov_pkg::*;
#(
    parameter int LANE_W    = 32,
    parameter int MAX_LANES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [LANE_W*MAX_LANES-1:0] src_vec,
    input  logic [LANE_W*MAX_LANES-1:0] dst_vec,
    input  logic [MAX_LANES-1:0]        lane_mask,
    input  logic                        mask_en,
    input  logic                        zero_sel,
    input  logic [1:0]                  vl_sel,
    input  logic [1:0]                  form_sel,
    input  logic [1:0]                  enc_sel,
    input  logic [3:0]                  rsvd_field,
    output logic                        out_valid,
    output logic [LANE_W*MAX_LANES-1:0] out_data,
    output logic                        out_fault
);
    localparam int MAX_W  = LANE_W * MAX_LANES;
    localparam int BASE_W = LANE_W * (MAX_LANES / 4);

    logic                 dec_fault;
    logic [MAX_LANES-1:0] lane_active;
    logic                 mask_on;
    logic                 is_store;
    logic                 clr_upper;
    logic [MAX_W-1:0]     lane_res;
    logic [MAX_W-1:0]     next_data;

    vmov_decode #(.MAX_LANES(MAX_LANES)) u_dec (
        .vl_sel      (vl_sel),
        .form_sel    (form_sel),
        .enc_sel     (enc_sel),
        .rsvd_field  (rsvd_field),
        .mask_en     (mask_en),
        .fault       (dec_fault),
        .lane_active (lane_active),
        .mask_on     (mask_on),
        .is_store    (is_store),
        .clr_upper   (clr_upper)
    );

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        vmov_lane #(.LANE_W(LANE_W)) u_lane (
            .src       (src_vec[j*LANE_W +: LANE_W]),
            .dst       (dst_vec[j*LANE_W +: LANE_W]),
            .active    (lane_active[j]),
            .pick      (!mask_on || lane_mask[j]),
            .is_store  (is_store),
            .clr_upper (clr_upper),
            .zero_mode (zero_sel),
            .res       (lane_res[j*LANE_W +: LANE_W])
        );
    end

    assign next_data = dec_fault ? dst_vec : lane_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= next_data;
                out_fault <= dec_fault;
            end
        end
    end

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_fault)));

    // R8
    rsvd_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field != 4'b1111) |=> (out_fault && out_data == $past(dst_vec)));

    // R5
    ext_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_fault && enc_sel != ENC_LEGACY && form_sel != FORM_STORE
         && vl_sel == VL_128) |=> (out_data[MAX_W-1:BASE_W] == '0));

    // R6
    store_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_fault && form_sel == FORM_STORE && vl_sel == VL_128)
        |=> (out_data[MAX_W-1:BASE_W] == $past(dst_vec[MAX_W-1:BASE_W])));

    // R7
    legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_fault && enc_sel == ENC_LEGACY && form_sel != FORM_STORE)
        |=> (out_data[MAX_W-1:BASE_W] == $past(dst_vec[MAX_W-1:BASE_W])));

endmodule

// File: tb/vmove_mask_unit_test.sv
module vmove_mask_unit_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [511:0] src_vec;
    logic [511:0] dst_vec;
    logic [15:0]  lane_mask;
    logic         mask_en;
    logic         zero_sel;
    logic [1:0]   vl_sel;
    logic [1:0]   form_sel;
    logic [1:0]   enc_sel;
    logic [3:0]   rsvd_field;
    logic         out_valid;
    logic [511:0] out_data;
    logic         out_fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vmove_mask_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec), .dst_vec(dst_vec),
        .lane_mask(lane_mask), .mask_en(mask_en), .zero_sel(zero_sel), .vl_sel(vl_sel),
        .form_sel(form_sel), .enc_sel(enc_sel), .rsvd_field(rsvd_field),
        .out_valid(out_valid), .out_data(out_data), .out_fault(out_fault)
    );

    task automatic check(input string req, input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic exp_fault(input int enc, input int form, input int vl, input int rs);
        return (rs != 15) || enc == 3 || form == 3 || vl == 3 ||
               (enc == 0 && vl != 0) || (enc == 1 && vl == 2);
    endfunction

    task automatic run_op(input int enc, input int form, input int vl, input int me,
                          input int zr, input logic [15:0] m, input int rs, input int cnum);
        logic [511:0] s;
        logic [511:0] d;
        logic         f;
        int           span;
        logic         mon;
        s = '0;
        d = '0;
        for (int j = 0; j < 16; j++) begin
            s[j*32 +: 32] = 32'hC000_0000 | (32'(cnum) << 8) | 32'(j);
            d[j*32 +: 32] = 32'h3000_0001 | (32'(cnum) << 8) | (32'(j) << 4);
        end
        @(negedge clk);
        enc_sel = 2'(enc); form_sel = 2'(form); vl_sel = 2'(vl);
        mask_en = 1'(me); zero_sel = 1'(zr); lane_mask = m; rsvd_field = 4'(rs);
        src_vec = s; dst_vec = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", {511'd0, out_valid}, 512'd1);
        f = exp_fault(enc, form, vl, rs);
        check(rs != 15 ? "R8" : "R9", {511'd0, out_fault}, {511'd0, f});
        span = 4 << vl;
        mon  = (enc == 2) && (me == 1);
        for (int j = 0; j < 16; j++) begin
            logic [31:0] e;
            string       t;
            if (f) begin
                e = d[j*32 +: 32]; t = (rs != 15) ? "R8" : "R9";
            end else if (j < span) begin
                if (!mon || m[j]) begin
                    e = s[j*32 +: 32]; t = (!m[j]) ? "R10" : "R1";
                end else if (form == 2) begin
                    e = d[j*32 +: 32]; t = "R4";
                end else if (zr == 1) begin
                    e = 32'd0; t = "R3";
                end else begin
                    e = d[j*32 +: 32]; t = "R2";
                end
            end else if (form == 2) begin
                e = d[j*32 +: 32]; t = "R6";
            end else if (enc == 0) begin
                e = d[j*32 +: 32]; t = "R7";
            end else begin
                e = 32'd0; t = "R5";
            end
            check(t, {480'd0, out_data[j*32 +: 32]}, {480'd0, e});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0]  masks [4];
        logic [511:0] held;
        int           cnum;
        masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'hA5C3; masks[3] = 16'h0F0F;
        rst = 1'b1; in_valid = 1'b0; src_vec = '0; dst_vec = '0; lane_mask = '0;
        mask_en = 1'b0; zero_sel = 1'b0; vl_sel = '0; form_sel = '0; enc_sel = '0;
        rsvd_field = 4'hF;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {511'd0, out_valid}, 512'd0);
        check("R11", out_data, 512'd0);
        check("R11", {511'd0, out_fault}, 512'd0);
        rst = 1'b0;
        cnum = 0;
        for (int rsi = 0; rsi < 2; rsi++)
            for (int enc = 0; enc < 4; enc++)
                for (int form = 0; form < 4; form++)
                    for (int vl = 0; vl < 4; vl++)
                        for (int me = 0; me < 2; me++)
                            for (int zr = 0; zr < 2; zr++)
                                for (int mi = 0; mi < 4; mi++) begin
                                    run_op(enc, form, vl, me, zr, masks[mi],
                                           rsi == 0 ? 15 : 7, cnum);
                                    cnum++;
                                end
        // R8: every reserved value on a masked zeroing load
        for (int rs = 0; rs < 16; rs++) begin
            run_op(2, 1, 2, 1, 1, 16'h5A5A, rs, cnum);
            cnum++;
        end
        // R11: idle cycle holds output
        held = out_data;
        @(negedge clk);
        check("R11", {511'd0, out_valid}, 512'd0);
        check("R11", out_data, held);
        // R12: NaN and denormal patterns pass unchanged
        @(negedge clk);
        for (int j = 0; j < 16; j++)
            src_vec[j*32 +: 32] = (j % 2 == 0) ? (32'h7FC0_0001 + 32'(j)) : (32'h0000_0003 + 32'(j));
        enc_sel = 2'd2; form_sel = 2'd1; vl_sel = 2'd2; mask_en = 1'b0; zero_sel = 1'b0;
        rsvd_field = 4'hF; in_valid = 1'b1;
        held = src_vec;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12", out_data, held);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule